// File: doc/BRIEF.md
# Alarm Wake Power-On Controller

This block decides when a battery-backed real-time clock asks the system to turn its main supply on. It watches three events: the standby rail being present or absent, a power-on-reset pulse on that standby rail, and a match pulse from the second alarm comparator. It drives an open-drain style power-on request, which is modelled as a drive-low enable plus a float indication.

A single 8-bit control register decides the policy. The host writes and reads it through a simple port.
- A remember-enable bit lets an alarm that fires while the standby rail is absent be latched. The latched alarm is replayed as a power-on request once the rail is back.
- A wake bit turns a standby power-on reset into a power-on request.
- A stay-off bit makes such a reset leave the request floating, so main power stays off.
- A crystal load-capacitance select bit is only stored.

Any pending request is acknowledged and cleared when the main-power-good input goes high.

Top module: `pwr_wake_ctl`

## Requirements
- R1: After reset the control register reads 0x00 and the request floats: pon_float=1 and pon_drive_low=0. cfg_err is 0.
- R2: The control register bit positions are: bit 0 remember-enable, bit 1 stay-off, bit 2 POR-wake, bit 7 capacitor select (0 = larger load, 1 = smaller load). A write stores bits 0, 1, 2 and 7, and rd_data shows them in the cycle after the write edge. Bits 6:3 always read 0, and writes to them are ignored.
- R3: An alarm2_hit pulse sampled while stby_ok=0 and bit 0=1 is latched. The request stays floating while stby_ok=0. The request drives low as soon as stby_ok returns to 1.
- R4: An alarm2_hit pulse has no effect on the request in two cases: when it is sampled with stby_ok=1, or when it is sampled with bit 0=0.
- R5: A stby_por pulse sampled with bit 2=1 and bit 1=0 makes pon_drive_low=1 after that clock edge.
- R6: A stby_por pulse sampled with bit 1=1 leaves the request floating, whatever bit 2 holds, so stay-off wins. It also cancels a POR wake that is still pending.
- R7: A write that sets both bit 1 and bit 2 raises cfg_err after its edge. cfg_err is sticky until reset.
- R8: main_pg=1 sampled at an edge clears every latched request, so the request floats after that edge.
- R9: pon_float is always the complement of pon_drive_low. Bit 7 does not change the request behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| stby_ok | input | 1 | Standby rail present |
| stby_por | input | 1 | Standby power-on-reset pulse |
| alarm2_hit | input | 1 | Alarm-2 match pulse |
| main_pg | input | 1 | Main power good, acknowledges the request |
| pon_drive_low | output | 1 | Power-on request pin driven low |
| pon_float | output | 1 | Power-on request pin floating |
| cfg_err | output | 1 | Sticky: stay-off and POR-wake both set |

## Verification
A register write, an alarm pulse, a POR pulse and a main_pg acknowledge each take effect at the clock edge that samples them. Their results (rd_data, cfg_err, and the request outputs) are due one edge later. The exception is a remembered alarm: its request follows stby_ok combinationally, so it appears in the same cycle the rail returns. The bench drives inputs on the falling edge and reads register-driven results at the next falling edge. It reads the stby_ok-dependent request one nanosecond after changing stby_ok.

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl #(
  parameter int DW       = 8,
  parameter int B_REM    = 0,
  parameter int B_OFF    = 1,
  parameter int B_WAKE   = 2,
  parameter int B_CAP    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          stby_ok,
  input  logic          stby_por,
  input  logic          alarm2_hit,
  input  logic          main_pg,
  output logic          pon_drive_low,
  output logic          pon_float,
  output logic          cfg_err
);
  logic rem_q, off_q, wake_q, cap_q;
  logic mem_q, por_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= 1'b0;
      off_q  <= 1'b0;
      wake_q <= 1'b0;
      cap_q  <= 1'b0;
    end else if (wr_en) begin
      rem_q  <= wr_data[B_REM];
      off_q  <= wr_data[B_OFF];
      wake_q <= wr_data[B_WAKE];
      cap_q  <= wr_data[B_CAP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (wr_en && wr_data[B_OFF] && wr_data[B_WAKE]) err_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= 1'b0;
    else if (main_pg) mem_q <= 1'b0;
    else if (alarm2_hit && rem_q && !stby_ok) mem_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) por_q <= 1'b0;
    else if (main_pg) por_q <= 1'b0;
    else if (stby_por) por_q <= wake_q && !off_q;
  end

  always_comb begin
    rd_data         = '0;
    rd_data[B_REM]  = rem_q;
    rd_data[B_OFF]  = off_q;
    rd_data[B_WAKE] = wake_q;
    rd_data[B_CAP]  = cap_q;
  end

  assign pon_drive_low = por_q | (mem_q & stby_ok);
  assign pon_float     = ~pon_drive_low;
  assign cfg_err       = err_q;
endmodule

// File: rtl/pwr_wake_ctl_chk.sv
module pwr_wake_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       stby_ok,
  input logic       stby_por,
  input logic       alarm2_hit,
  input logic       main_pg,
  input logic       pon_drive_low,
  input logic       pon_float,
  input logic       cfg_err
);
  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_pg |=> !pon_drive_low);
  // R4
  alarm_present_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_ok && alarm2_hit && !stby_por && !pon_drive_low) |=> !pon_drive_low);
  // R5
  por_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_por && rd_data[2] && !rd_data[1] && !main_pg) |=> pon_drive_low);
  // R6
  stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_ok && stby_por && rd_data[1] && !alarm2_hit && !pon_drive_low) |=> !pon_drive_low);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R7
  err_on_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] && rd_data[2]) |-> cfg_err);
  // R9
  float_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pon_float != pon_drive_low);
endmodule

bind pwr_wake_ctl pwr_wake_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .stby_ok(stby_ok),
  .stby_por(stby_por), .alarm2_hit(alarm2_hit), .main_pg(main_pg),
  .pon_drive_low(pon_drive_low), .pon_float(pon_float), .cfg_err(cfg_err)
);

// File: tb/tb_pwr_wake_ctl.sv
module tb_pwr_wake_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic stby_ok = 1'b1, stby_por = 1'b0, alarm2_hit = 1'b0, main_pg = 1'b0;
  logic pon_drive_low, pon_float, cfg_err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_wake_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .stby_ok(stby_ok), .stby_por(stby_por), .alarm2_hit(alarm2_hit), .main_pg(main_pg),
    .pon_drive_low(pon_drive_low), .pon_float(pon_float), .cfg_err(cfg_err)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic req_is(string req, logic exp_low);
    check(req, {6'b0, pon_drive_low, pon_float}, {6'b0, exp_low, ~exp_low});
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_alarm();
    alarm2_hit = 1'b1; @(negedge clk); alarm2_hit = 1'b0;
  endtask

  task automatic pulse_por();
    stby_por = 1'b1; @(negedge clk); stby_por = 1'b0;
  endtask

  task automatic ack();
    main_pg = 1'b1; @(negedge clk); main_pg = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rd_data", rd_data, 8'h00);
    req_is("R1 request", 1'b0);
    check("R1 cfg_err", {7'b0, cfg_err}, 8'h00);
  endtask

  task automatic t_register();
    wr(8'h79); check("R2 reserved ignored", rd_data, 8'h01);
    wr(8'h85); check("R2 readback 85", rd_data, 8'h85);
    wr(8'hFB); check("R2 readback FB", rd_data, 8'h83);
    check("R2 no err", {7'b0, cfg_err}, 8'h00);
  endtask

  task automatic t_remember();
    wr(8'h01);
    @(negedge clk); stby_ok = 1'b0;
    @(negedge clk); pulse_alarm();
    req_is("R3 floats while rail absent", 1'b0);
    repeat (2) @(negedge clk);
    stby_ok = 1'b1; #1;
    req_is("R3 replay on rail return", 1'b1);
    @(negedge clk); ack();
    req_is("R8 ack clears remembered", 1'b0);
  endtask

  task automatic t_ignore();
    wr(8'h00);
    stby_ok = 1'b0; @(negedge clk); pulse_alarm();
    stby_ok = 1'b1; #1;
    req_is("R4 remember disabled", 1'b0);
    wr(8'h01);
    pulse_alarm();
    req_is("R4 rail present", 1'b0);
    stby_ok = 1'b0; @(negedge clk); stby_ok = 1'b1; #1;
    req_is("R4 nothing remembered", 1'b0);
  endtask

  task automatic t_por_wake();
    wr(8'h04); pulse_por();
    req_is("R5 por wake", 1'b1);
    ack(); req_is("R8 ack clears por", 1'b0);
    wr(8'h84); pulse_por();
    req_is("R9 cap bit no effect", 1'b1);
    ack();
  endtask

  task automatic t_stay_off();
    wr(8'h02); pulse_por();
    req_is("R6 stay-off floats", 1'b0);
    wr(8'h04); pulse_por();
    req_is("R6 pending wake set", 1'b1);
    wr(8'h02); pulse_por();
    req_is("R6 stay-off cancels pending", 1'b0);
  endtask

  task automatic t_conflict();
    check("R7 err clear before", {7'b0, cfg_err}, 8'h00);
    wr(8'h06);
    check("R7 err raised", {7'b0, cfg_err}, 8'h01);
    check("R2 conflict readback", rd_data, 8'h06);
    pulse_por();
    req_is("R6 stay-off wins", 1'b0);
    wr(8'h00);
    check("R7 err sticky", {7'b0, cfg_err}, 8'h01);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_register();
    t_remember();
    t_ignore();
    t_por_wake();
    t_stay_off();
    t_conflict();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule